// File: doc/BRIEF.md
# Password-Guarded Watchdog and Interval Timer

This block counts ticks from one of two external clock-enable strobes and, when the selected terminal count is reached, either requests a system reset (watchdog mode) or raises a sticky interrupt flag (interval mode). Software keeps a watchdog alive by writing its 16-bit control word again before the terminal count is reached, because every accepted write restarts the count from zero.

The control word is protected by a key in its upper byte. A write with key 0x5A stores the lower byte. A write with any other key requests a reset and leaves the stored control byte as it was. The control byte holds a hold bit, a strobe select bit, a mode bit, a write-only restart bit and a two-bit interval select. Reading gives the stored byte with 0x69 in the upper byte.

Top module: `wdt_timer`

## Requirements
- R1: After reset the read word is 0x6900, and rst_req_o and irq_o are 0.
- R2: A write whose bits 15:8 equal 0x5A stores bits 7:0 as the control byte, visible on rd_data_o[7:0] the cycle after the write edge. Bit 3 (restart) always reads 0 and bits 15:8 always read 0x69.
- R3: A write whose bits 15:8 differ from 0x5A raises rst_req_o for exactly the one cycle after the write edge, leaves the control byte unchanged and restarts the count from zero.
- R4: While control bit 7 (hold) is 1, no tick is counted and neither rst_req_o nor irq_o is raised by expiry.
- R5: Control bit 2 selects the counted strobe: 1 counts tick_aux_i, 0 counts tick_main_i. The other strobe has no effect.
- R6: Control bits 1:0 select the terminal count: 0 gives 32768 ticks, 1 gives 8192, 2 gives 512 and 3 gives 64.
- R7: With bit 4 at 0 (watchdog mode), the terminal tick raises rst_req_o for exactly one cycle, in the cycle after the edge that samples that tick. Counting then restarts from zero.
- R8: With bit 4 at 1 (interval mode), the terminal tick sets irq_o in the cycle after the edge that samples it and does not raise rst_req_o. Counting restarts, so irq_o is set again after each further full period.
- R9: Every accepted write restarts the count from zero. A tick sampled on the same edge as the write is not counted.
- R10: irq_o stays set until irq_ack_i is sampled high. If an interval expiry and irq_ack_i fall on the same edge, irq_o stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 16 | Control word write data, key in bits 15:8 |
| rd_data_o | output | 16 | Control word read data |
| tick_aux_i | input | 1 | Auxiliary tick strobe |
| tick_main_i | input | 1 | Main tick strobe |
| irq_ack_i | input | 1 | Clears the interval interrupt flag |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Sticky interval interrupt flag |

## Verification
Every result of this block is due exactly one cycle after the edge that samples its cause: the readback after a write edge, a key-violation reset pulse after the write edge, and an expiry pulse or interrupt after the edge that samples the terminal tick. The driver applies each stimulus just after a rising edge and queues the expected values tagged with the cycle number in which they must appear. The monitor compares them at the following falling edge, so a pulse one cycle early or late is reported. Counts one tick short of the terminal are checked to stay quiet. A bench counter of reset-request cycles catches any extra pulse in long hold or wrong-strobe windows.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;
  localparam int unsigned N_ISEL = 4;
  localparam int unsigned TERM_DEF [N_ISEL] = '{32768, 8192, 512, 64};

  typedef struct packed {
    logic       hold;   // 7
    logic [1:0] spare;  // 6:5
    logic       ival;   // 4: interval mode
    logic       rst;    // 3: restart, write-only
    logic       aux;    // 2: count aux strobe
    logic [1:0] isel;   // 1:0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '0;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output ctrl_t       ctrl_o,
  output logic        restart_o,
  output logic        bad_key_o
);
  logic  key_ok;
  ctrl_t ctrl_q, ctrl_d;

  assign key_ok    = (wr_data_i[15:8] == WR_KEY);
  assign restart_o = wr_en_i;
  assign bad_key_o = wr_en_i & ~key_ok;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && key_ok) begin
      ctrl_d     = ctrl_t'(wr_data_i[7:0]);
      ctrl_d.rst = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel (
  input  logic tick_aux_i,
  input  logic tick_main_i,
  input  logic sel_aux_i,
  input  logic run_i,
  output logic tick_o
);
  assign tick_o = run_i & (sel_aux_i ? tick_aux_i : tick_main_i);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TERM_TBL [N_ISEL] = TERM_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] isel_i,
  output logic       expire_o
);
  logic [CNT_W-1:0] last_tbl [N_ISEL];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  for (genvar g = 0; g < N_ISEL; g++) begin : g_tbl
    assign last_tbl[g] = CNT_W'(TERM_TBL[g] - 1);
  end

  assign at_last  = (cnt_q == last_tbl[isel_i]);
  assign expire_o = tick_i & at_last & ~clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ival_i,
  input  logic bad_key_i,
  input  logic irq_ack_i,
  output logic rst_req_o,
  output logic irq_o
);
  logic rst_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      rst_q <= bad_key_i | (expire_i & ~ival_i);
      irq_q <= (expire_i & ival_i) | (irq_q & ~irq_ack_i);
    end
  end

  assign rst_req_o = rst_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TERM_TBL [N_ISEL] = TERM_DEF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic        tick_aux_i,
  input  logic        tick_main_i,
  input  logic        irq_ack_i,
  output logic        rst_req_o,
  output logic        irq_o
);
  ctrl_t ctrl;
  logic  restart, bad_key, tick, expire;

  wdt_ctrl_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .ctrl_o(ctrl), .restart_o(restart), .bad_key_o(bad_key)
  );

  wdt_tick_sel u_sel (
    .tick_aux_i, .tick_main_i,
    .sel_aux_i(ctrl.aux), .run_i(~ctrl.hold), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .TERM_TBL(TERM_TBL)) u_cnt (
    .clk_i, .rst_ni, .clr_i(restart), .tick_i(tick),
    .isel_i(ctrl.isel), .expire_o(expire)
  );

  wdt_event u_evt (
    .clk_i, .rst_ni, .expire_i(expire), .ival_i(ctrl.ival),
    .bad_key_i(bad_key), .irq_ack_i, .rst_req_o, .irq_o
  );

  assign rd_data_o = {RD_KEY, ctrl};
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        irq_ack_i,
  input logic        rst_req_o,
  input logic        irq_o,
  input logic        expire_i
);
  logic wr_ok, wr_bad;
  assign wr_ok  = wr_en_i && (wr_data_i[15:8] == 8'h5A);
  assign wr_bad = wr_en_i && (wr_data_i[15:8] != 8'h5A);

  a_r2_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> rd_data_o[7:0] == ($past(wr_data_i[7:0]) & 8'hF7));

  a_r3_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad |=> rst_req_o && $stable(rd_data_o));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] && !wr_en_i |=> !rst_req_o && !$rose(irq_o));

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o && !wr_bad |=> !rst_req_o);

  a_r8_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> rd_data_o[4]);

  a_r8_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && rd_data_o[4] |=> irq_o);

  a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> !rst_req_o && !$rose(irq_o));

  a_r10_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && !expire_i |=> !irq_o);
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
  .irq_ack_i, .rst_req_o, .irq_o, .expire_i(expire)
);

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        tick_aux_i = 1'b0;
  logic        tick_main_i = 1'b0;
  logic        irq_ack_i = 1'b0;
  logic        rst_req_o;
  logic        irq_o;

  always #10 clk_i = ~clk_i;

  wdt_timer dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .tick_aux_i, .tick_main_i, .irq_ack_i, .rst_req_o, .irq_o
  );

  typedef struct {
    int          cyc;
    logic [15:0] rd;
    logic        rst;
    logic        irq;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  int npulse = 0;
  logic [7:0] e_ctrl = 8'h00;
  logic       e_irq = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor
  always @(negedge clk_i) begin
    if (rst_req_o) npulse++;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (it.cyc < cyc) begin
        bad++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", it.req, it.cyc, cyc);
      end else if (rd_data_o !== it.rd || rst_req_o !== it.rst || irq_o !== it.irq) begin
        bad++;
        $display("FAIL %s: rd=%h rst=%b irq=%b expected rd=%h rst=%b irq=%b",
                 it.req, rd_data_o, rst_req_o, irq_o, it.rd, it.rst, it.irq);
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_now(input logic rst, input string req);
    item_t it;
    it.cyc = cyc; it.rd = {8'h69, e_ctrl}; it.rst = rst; it.irq = e_irq; it.req = req;
    q.push_back(it);
  endtask

  task automatic check_eq(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic tick = 1'b0);
    wr_en_i = 1'b1; wr_data_i = d; tick_main_i = tick;
    step();
    wr_en_i = 1'b0; tick_main_i = 1'b0;
    if (d[15:8] == 8'h5A) e_ctrl = d[7:0] & 8'hF7;
  endtask

  task automatic ticks(input logic aux, input logic main, input int k);
    for (int i = 0; i < k; i++) begin
      tick_aux_i = aux; tick_main_i = main;
      step();
    end
    tick_aux_i = 1'b0; tick_main_i = 1'b0;
  endtask

  task automatic expiry_edge(input int term, input string req);
    ticks(1'b0, 1'b1, term - 1);
    expect_now(1'b0, req);
    ticks(1'b0, 1'b1, 1);
    expect_now(1'b1, req);
    step();
    expect_now(1'b0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    step(); step();
    rst_ni = 1'b1;
    step();
    expect_now(1'b0, "R1 reset state");

    // R2 store and readback
    wr(16'h5A0B);
    expect_now(1'b0, "R2 restart bit reads 0");
    wr(16'h5A63);
    expect_now(1'b0, "R2 spare bits stored");

    // R7 watchdog expiry at 64 ticks, one-cycle pulse
    wr(16'h5A03);
    expect_now(1'b0, "R2 write 0x03");
    expiry_edge(64, "R7 watchdog expiry");

    // R5 source select
    p0 = npulse;
    ticks(1'b1, 1'b0, 80);
    check_eq(npulse - p0, 0, "R5 aux ignored when main selected");
    wr(16'h5A07);
    expect_now(1'b0, "R5 select aux");
    p0 = npulse;
    ticks(1'b0, 1'b1, 80);
    check_eq(npulse - p0, 0, "R5 main ignored when aux selected");
    ticks(1'b1, 1'b0, 63);
    expect_now(1'b0, "R5 aux one short");
    ticks(1'b1, 1'b0, 1);
    expect_now(1'b1, "R5 aux expiry");

    // R9 write restarts, tick on write edge not counted
    wr(16'h5A03);
    ticks(1'b0, 1'b1, 40);
    wr(16'h5A03, 1'b1);
    expect_now(1'b0, "R9 rewrite");
    expiry_edge(64, "R9 count restarted");

    // R3 wrong key
    ticks(1'b0, 1'b1, 30);
    wr(16'hA583);
    expect_now(1'b1, "R3 wrong key pulse, ctrl kept");
    step();
    expect_now(1'b0, "R3 pulse one cycle");
    wr(16'h5900);
    expect_now(1'b1, "R3 key 0x59");
    expiry_edge(64, "R3 count restarted");

    // R4 hold
    wr(16'h5A83);
    expect_now(1'b0, "R4 hold set");
    p0 = npulse;
    ticks(1'b0, 1'b1, 200);
    ticks(1'b1, 1'b0, 200);
    check_eq(npulse - p0, 0, "R4 no expiry in hold");
    expect_now(1'b0, "R4 no event in hold");

    // R8 interval mode
    wr(16'h5A13);
    p0 = npulse;
    ticks(1'b0, 1'b1, 63);
    expect_now(1'b0, "R8 one short");
    ticks(1'b0, 1'b1, 1);
    e_irq = 1'b1;
    expect_now(1'b0, "R8 irq set");
    ticks(1'b0, 1'b1, 64);
    expect_now(1'b0, "R8 irq stays");
    check_eq(npulse - p0, 0, "R8 no reset in interval mode");
    // R10 ack
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
    e_irq = 1'b0;
    expect_now(1'b0, "R10 ack clears");
    ticks(1'b0, 1'b1, 63);
    expect_now(1'b0, "R8 second period one short");
    irq_ack_i = 1'b1;
    ticks(1'b0, 1'b1, 1);
    irq_ack_i = 1'b0;
    e_irq = 1'b1;
    expect_now(1'b0, "R10 set wins over ack");
    irq_ack_i = 1'b1; step(); irq_ack_i = 1'b0;
    e_irq = 1'b0;
    expect_now(1'b0, "R10 ack clears again");

    // R6 table
    wr(16'h5A02);
    expiry_edge(512, "R6 isel 2");
    wr(16'h5A01);
    expiry_edge(8192, "R6 isel 1");
    wr(16'h5A00);
    expiry_edge(32768, "R6 isel 0");

    step(); step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule